// File: doc/BRIEF.md
# Address-Triggered Move Processor

This block is a tiny processor that has no opcode field. Each 32-bit instruction word holds two 16-bit addresses. Executing it copies one 16-bit word from the source address to the destination address. The work of the machine comes from where the word lands. Some addresses are ports of functional units: an accumulator with an add input and a sum register, and a two-operand multiplier with an operand input and a product register. Four independent copies of each unit sit at a 256-address stride.

The program counter also has an address of its own. Moving a word there is a jump, and reading it yields the address of the instruction doing the read. Every other address reaches a small data RAM.

Instructions come from an external instruction memory, which the processor addresses with its program counter. The result of each move is driven onto a store bus (valid, address, data) for the cycle in which the move lands. That bus is the only window onto the machine's activity.

Top module: `ttp_core`

## Requirements
- R1: An instruction word carries the source address in bits [31:16] and the destination address in bits [15:0]. Executing it delivers the word read at the source to the destination, and shows the destination and the word on `st_addr` and `st_data`.
- R2: Each instruction takes exactly two cycles. In the first (fetch) cycle `st_valid` is 0 and the source is read. In the second (store) cycle `st_valid` is 1 and the destination is written.
- R3: `imem_addr` holds the program counter. It stays stable during fetch, and after a store to any address other than the program counter it advances by exactly 1.
- R4: The program counter is mapped at address 0x0010, in bank 0 only. Reading it returns the address of the executing instruction. Writing it makes the written value the next fetch address, with no increment.
- R5: Writing offset 0 of an accumulator copy adds the word to its sum, wrapping modulo 2^16.
- R6: Writing offset 4 of an accumulator copy loads its sum with the word. Reading offset 4 returns the sum.
- R7: Writing offset 8 of a multiplier copy twice in a row supplies the first operand, then the second operand. Reading offset 12 returns the low 16 bits of their product from the third instruction after the one that wrote the second operand. The first and second instructions after it still read the previous product.
- R8: Copy k (k = 0..3) of both units sits at offset + 256*k, and every copy keeps its own state.
- R9: Any address that is not 0x0010 and not a unit port is data RAM, indexed by its low 6 bits. This covers non-port offsets in every bank, 0x0110, and every address at or above 0x0400.
- R10: Reset sets the program counter to 0, every accumulator sum and product to 0, and the operand order of every multiplier back to "first operand". During reset `st_valid` is 0.
- R11: Reading an accumulator add input (offset 0) or a multiplier operand input (offset 8) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Instruction address (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| st_valid | output | 1 | High in the store cycle of every instruction |
| st_addr | output | 16 | Destination address of the current move |
| st_data | output | 16 | Word being moved |

## Verification
A wrong program counter shows up on `imem_addr` at the very next fetch, one cycle after the faulty store. That makes a bad increment or a missed jump visible within two cycles. Unit state has no port of its own, so a wrong sum, a swapped operand or a product taken too early becomes visible only when a later move reads that unit and drives the value onto `st_data`. The program therefore reads every unit back, at chosen distances after each write. The third instruction after a second operand is the earliest one that may see the new product, and the two instructions before it must still see the old one, so a latency error shows within six cycles. Reads of a different copy after each write expose state that leaks between copies.

// File: rtl/ttp_pkg.sv
package ttp_pkg;

  typedef enum logic [2:0] {
    PK_RAM,
    PK_PC,
    PK_ACC_IN,
    PK_ACC_SUM,
    PK_MUL_IN,
    PK_MUL_OUT
  } port_kind_e;

  typedef enum logic {
    PH_FETCH,
    PH_STORE
  } phase_e;

  // port offsets inside one unit bank
  localparam int OFF_ACC_IN  = 0;
  localparam int OFF_ACC_SUM = 4;
  localparam int OFF_MUL_IN  = 8;
  localparam int OFF_MUL_OUT = 12;

endpackage

// File: rtl/ttp_decode.sv
module ttp_decode
  import ttp_pkg::*;
#(
  parameter int AW         = 16,
  parameter int STRIDE_LOG = 8,
  parameter int N_COPY     = 4,
  parameter int PC_ADDR    = 16,
  localparam int CP_W      = (N_COPY > 1) ? $clog2(N_COPY) : 1
) (
  input  logic [AW-1:0]   addr,
  output port_kind_e      kind,
  output logic [CP_W-1:0] copy
);

  localparam int HI_LSB = STRIDE_LOG + CP_W;

  logic [STRIDE_LOG-1:0] off;
  logic                  hi_zero;

  assign off     = addr[STRIDE_LOG-1:0];
  assign copy    = addr[STRIDE_LOG +: CP_W];
  assign hi_zero = (addr >> HI_LSB) == '0;

  always_comb begin
    kind = PK_RAM;
    if (addr == AW'(PC_ADDR)) begin
      kind = PK_PC;
    end else if (hi_zero && (int'(copy) < N_COPY)) begin
      case (off)
        STRIDE_LOG'(OFF_ACC_IN):  kind = PK_ACC_IN;
        STRIDE_LOG'(OFF_ACC_SUM): kind = PK_ACC_SUM;
        STRIDE_LOG'(OFF_MUL_IN):  kind = PK_MUL_IN;
        STRIDE_LOG'(OFF_MUL_OUT): kind = PK_MUL_OUT;
        default:                  kind = PK_RAM;
      endcase
    end
  end

endmodule

// File: rtl/ttp_acc.sv
module ttp_acc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_add,
  input  logic          wr_load,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] sum
);

  function automatic logic [DW-1:0] acc_sum_f(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  logic [DW-1:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sum_q <= '0;
    else if (wr_load) sum_q <= wdata;
    else if (wr_add)  sum_q <= acc_sum_f(sum_q, wdata);
  end

  assign sum = sum_q;

  // R5
  acc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_add && !wr_load) |=> sum_q == DW'($past(sum_q) + $past(wdata)));

  // R6
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> sum_q == $past(wdata));

endmodule

// File: rtl/ttp_mul.sv
module ttp_mul #(
  parameter int DW  = 16,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_in,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] prod
);

  localparam int CW = $clog2(LAT + 1);

  function automatic logic [DW-1:0] mul_lo_f(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [2*DW-1:0] full;
    full = a * b;
    return full[DW-1:0];
  endfunction

  logic          have_a_q;
  logic [DW-1:0] opa_q, pend_a_q, pend_b_q, prod_q;
  logic [CW-1:0] cnt_q;
  logic          wr_second, fire, busy;

  assign wr_second = wr_in && have_a_q;
  assign fire      = cnt_q == CW'(1);
  assign busy      = cnt_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_a_q <= 1'b0;
      opa_q    <= '0;
      pend_a_q <= '0;
      pend_b_q <= '0;
      prod_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_in) begin
        have_a_q <= !have_a_q;
        if (!have_a_q) opa_q <= wdata;
      end
      if (wr_second) begin
        pend_a_q <= opa_q;
        pend_b_q <= wdata;
        cnt_q    <= CW'(LAT);
      end else if (busy) begin
        cnt_q <= cnt_q - CW'(1);
      end
      if (fire) prod_q <= mul_lo_f(pend_a_q, pend_b_q);
    end
  end

  assign prod = prod_q;

  // R7
  mul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(prod_q));

  // R7
  mul_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_second |-> !busy);

endmodule

// File: rtl/ttp_dmem.sv
module ttp_dmem #(
  parameter int DW     = 16,
  parameter int RAM_AW = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RAM_AW-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [RAM_AW-1:0] raddr,
  output logic [DW-1:0]     rdata
);

  localparam int DEPTH = 1 << RAM_AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ttp_core.sv
module ttp_core
  import ttp_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int RAM_AW     = 6,
  parameter int N_COPY     = 4,
  parameter int STRIDE_LOG = 8,
  parameter int MUL_LAT    = 3,
  parameter int PC_ADDR    = 16,
  localparam int IW        = 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [IW-1:0] imem_data,
  output logic          st_valid,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data
);

  localparam int CP_W = (N_COPY > 1) ? $clog2(N_COPY) : 1;

  phase_e        phase_q;
  logic [AW-1:0] pc_q, dst_q;
  logic [DW-1:0] mdr_q;

  logic [AW-1:0] src_a, dst_a;
  assign src_a = imem_data[IW-1:AW];
  assign dst_a = imem_data[AW-1:0];

  port_kind_e      skind, dkind;
  logic [CP_W-1:0] scopy, dcopy;

  ttp_decode #(.AW(AW), .STRIDE_LOG(STRIDE_LOG), .N_COPY(N_COPY), .PC_ADDR(PC_ADDR))
    u_src_dec (.addr(src_a), .kind(skind), .copy(scopy));

  ttp_decode #(.AW(AW), .STRIDE_LOG(STRIDE_LOG), .N_COPY(N_COPY), .PC_ADDR(PC_ADDR))
    u_dst_dec (.addr(dst_q), .kind(dkind), .copy(dcopy));

  // named store-side events
  logic in_store, wr_pc, wr_ram;
  assign in_store = phase_q == PH_STORE;
  assign wr_pc    = in_store && dkind == PK_PC;
  assign wr_ram   = in_store && dkind == PK_RAM;

  logic [N_COPY-1:0][DW-1:0] acc_sum, mul_prod;

  for (genvar g = 0; g < N_COPY; g++) begin : g_unit
    logic hit;
    assign hit = in_store && dcopy == CP_W'(g);

    ttp_acc #(.DW(DW)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .wr_add (hit && dkind == PK_ACC_IN),
      .wr_load(hit && dkind == PK_ACC_SUM),
      .wdata(mdr_q), .sum(acc_sum[g]));

    ttp_mul #(.DW(DW), .LAT(MUL_LAT)) u_mul (
      .clk(clk), .rst_n(rst_n),
      .wr_in(hit && dkind == PK_MUL_IN),
      .wdata(mdr_q), .prod(mul_prod[g]));
  end

  logic [DW-1:0] ram_rdata;

  ttp_dmem #(.DW(DW), .RAM_AW(RAM_AW)) u_dmem (
    .clk(clk), .we(wr_ram),
    .waddr(dst_q[RAM_AW-1:0]), .wdata(mdr_q),
    .raddr(src_a[RAM_AW-1:0]), .rdata(ram_rdata));

  logic [DW-1:0] rd_word;

  always_comb begin
    case (skind)
      PK_PC:      rd_word = DW'(pc_q);
      PK_ACC_SUM: rd_word = acc_sum[scopy];
      PK_MUL_OUT: rd_word = mul_prod[scopy];
      PK_RAM:     rd_word = ram_rdata;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= '0;
      dst_q   <= '0;
      mdr_q   <= '0;
    end else if (phase_q == PH_FETCH) begin
      mdr_q   <= rd_word;
      dst_q   <= dst_a;
      phase_q <= PH_STORE;
    end else begin
      pc_q    <= wr_pc ? AW'(mdr_q) : pc_q + AW'(1);
      phase_q <= PH_FETCH;
    end
  end

  assign imem_addr = pc_q;
  assign st_valid  = in_store;
  assign st_addr   = dst_q;
  assign st_data   = mdr_q;

  // R2
  phase_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);

  // R2
  phase_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> st_valid);

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> $stable(imem_addr));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !wr_pc) |=> imem_addr == AW'($past(imem_addr) + AW'(1)));

  // R4
  pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pc |=> imem_addr == AW'($past(st_data)));

endmodule

// File: tb/tb_ttp_core.sv
module tb_ttp_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr;
  logic [31:0] imem_data;
  logic        st_valid;
  logic [15:0] st_addr;
  logic [15:0] st_data;

  always #10 clk = !clk;

  logic [31:0] imem [64];
  assign imem_data = imem[imem_addr[5:0]];

  ttp_core dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // {pc, src, dst, expected word, requirement}; executed order
  localparam int NT = 43;
  localparam logic [79:0] TRACE [NT] = '{
    {16'h00, 16'h0004, 16'h0020, 16'h0000, 16'd10}, // R10 acc0 reset
    {16'h01, 16'h000C, 16'h0021, 16'h0000, 16'd10}, // R10 mul0 reset
    {16'h02, 16'h0010, 16'h0000, 16'h0002, 16'd4},  // R4 pc read, acc0=2
    {16'h03, 16'h0010, 16'h0000, 16'h0003, 16'd5},  // R5 acc0=5
    {16'h04, 16'h0004, 16'h0022, 16'h0005, 16'd5},  // R5 sum read
    {16'h05, 16'h0010, 16'h0008, 16'h0005, 16'd7},  // R7 op1
    {16'h06, 16'h0010, 16'h0008, 16'h0006, 16'd7},  // R7 op2
    {16'h07, 16'h000C, 16'h0023, 16'h0000, 16'd7},  // R7 +1 old
    {16'h08, 16'h000C, 16'h0024, 16'h0000, 16'd7},  // R7 +2 old
    {16'h09, 16'h000C, 16'h0025, 16'h001E, 16'd7},  // R7 +3 new
    {16'h0A, 16'h0022, 16'h0104, 16'h0005, 16'd6},  // R6 load acc1
    {16'h0B, 16'h0022, 16'h0100, 16'h0005, 16'd8},  // R8 add acc1
    {16'h0C, 16'h0104, 16'h0026, 16'h000A, 16'd6},  // R6 acc1=10
    {16'h0D, 16'h0004, 16'h0027, 16'h0005, 16'd8},  // R8 acc0 untouched
    {16'h0E, 16'h0000, 16'h0028, 16'h0000, 16'd11}, // R11
    {16'h0F, 16'h0008, 16'h0029, 16'h0000, 16'd11}, // R11
    {16'h10, 16'h0025, 16'h0308, 16'h001E, 16'd8},  // R8 mul3 op1
    {16'h11, 16'h0025, 16'h0308, 16'h001E, 16'd8},  // R8 mul3 op2
    {16'h12, 16'h000C, 16'h002A, 16'h001E, 16'd8},  // R8 mul0 kept
    {16'h13, 16'h0020, 16'h0004, 16'h0000, 16'd6},  // R6 clear acc0
    {16'h14, 16'h030C, 16'h002B, 16'h0384, 16'd8},  // R8 mul3=900
    {16'h15, 16'h0004, 16'h002C, 16'h0000, 16'd6},  // R6
    {16'h16, 16'h0010, 16'h0000, 16'h0016, 16'd5},  // R5 acc0=22
    {16'h17, 16'h0026, 16'h0000, 16'h000A, 16'd5},  // R5 acc0=32
    {16'h18, 16'h0004, 16'h0010, 16'h0020, 16'd4},  // R4 jump to 32
    {16'h20, 16'h0010, 16'h002D, 16'h0020, 16'd4},  // R4
    {16'h21, 16'h002D, 16'h0105, 16'h0020, 16'd9},  // R9 bank1 ram
    {16'h22, 16'h0105, 16'h002E, 16'h0020, 16'd9},  // R9
    {16'h23, 16'h0010, 16'h0110, 16'h0023, 16'd9},  // R9 0x0110 ram
    {16'h24, 16'h0110, 16'h002F, 16'h0023, 16'd9},  // R9
    {16'h25, 16'h0010, 16'h0400, 16'h0025, 16'd9},  // R9 high ram
    {16'h26, 16'h0400, 16'h0030, 16'h0025, 16'd9},  // R9
    {16'h27, 16'h002D, 16'h0008, 16'h0020, 16'd7},  // R7 op1=32
    {16'h28, 16'h0022, 16'h0008, 16'h0005, 16'd7},  // R7 op2=5
    {16'h29, 16'h000C, 16'h0031, 16'h001E, 16'd7},  // R7 +1 old
    {16'h2A, 16'h0004, 16'h0032, 16'h0020, 16'd3},  // R3
    {16'h2B, 16'h000C, 16'h0033, 16'h00A0, 16'd7},  // R7 160
    {16'h2C, 16'h030C, 16'h0308, 16'h0384, 16'd8},  // R8 op1
    {16'h2D, 16'h030C, 16'h0308, 16'h0384, 16'd8},  // R8 op2
    {16'h2E, 16'h0004, 16'h0034, 16'h0020, 16'd3},  // R3
    {16'h2F, 16'h0004, 16'h0035, 16'h0020, 16'd3},  // R3
    {16'h30, 16'h030C, 16'h0036, 16'h5C10, 16'd7},  // R7 low 16 bits
    {16'h31, 16'h0010, 16'h0010, 16'h0031, 16'd4}   // R4 self jump
  };

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = {16'h0010, 16'h0010};
    for (int i = 0; i < NT; i++) imem[TRACE[i][74:64]] = TRACE[i][63:32];
    imem[25] = {16'h0010, 16'h0020}; // must be skipped by the jump
  end

  initial begin
    repeat (3) @(negedge clk);
    check(10, "reset st_valid", 32'(st_valid), 32'd0);   // R10
    check(10, "reset pc", 32'(imem_addr), 32'd0);        // R10
    rst_n = 1'b1;
    for (int i = 0; i < NT; i++) begin
      #1;
      check(3, "fetch pc", 32'(imem_addr), 32'(TRACE[i][79:64]));  // R3
      check(2, "fetch idle", 32'(st_valid), 32'd0);                // R2
      @(negedge clk);
      #1;
      check(2, "store valid", 32'(st_valid), 32'd1);               // R2
      check(1, "store addr", 32'(st_addr), 32'(TRACE[i][47:32]));  // R1
      check(int'(TRACE[i][15:0]), "store data", 32'(st_data), 32'(TRACE[i][31:16]));
      @(negedge clk);
    end
    for (int k = 0; k < 2; k++) begin
      #1;
      check(4, "self jump pc", 32'(imem_addr), 32'h31);            // R4
      repeat (2) @(negedge clk);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule